// File: doc/BRIEF.md
# Counted Loop and Relative Jump Sequencer

This block keeps a program position and a 32-bit iteration counter for an instruction stream. On each step it gets three things: the kind of instruction that retires in that cycle, its length in bytes, and a signed 8-bit displacement. From these it computes the next program position and the next counter value. A sequential instruction moves the position past itself. An unconditional relative jump always goes to its target. A counted loop first decrements the counter and branches back only when the decremented value is still nonzero.

Branch targets are measured from the first byte after the current instruction. The displacement is sign-extended, so a target can lie up to 128 bytes before that point or up to 127 bytes after it. Position arithmetic wraps modulo the position width. A separate preset port writes the counter directly. Fetch, decode and every other architectural register live outside the block. The block has no flags and changes none.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst_n` is low, `ip_q` and `cnt_q` are both zero, and they stay zero until the first step or preset after reset is released.
- R2: A step of kind 2'b00 (sequential) sets `ip_q` to `ip_q + step_len` and leaves `cnt_q` unchanged, unless a preset is applied in the same cycle.
- R3: A step of kind 2'b01 (jump) always sets `ip_q` to `ip_q + step_len + sext(step_ofs)` and leaves `cnt_q` unchanged, unless a preset is applied in the same cycle.
- R4: A step of kind 2'b10 (loop) sets `cnt_q` to `cnt_q - 1`. When that new count is nonzero, `ip_q` becomes the relative target of R3. When the new count is zero, `ip_q` becomes `ip_q + step_len`.
- R5: A loop step taken with `cnt_q` equal to zero wraps the count to all ones and takes the branch, so a zero start gives 2^32 iterations.
- R6: `step_ofs` is two's complement, so 8'h80 moves the target 128 bytes back and 8'h7F moves it 127 bytes forward. All position arithmetic wraps modulo 2^IP_W.
- R7: A 2-byte loop instruction at position 0x0C with displacement 8'hFC and a count of 3 moves `ip_q` to 0x0A and `cnt_q` to 2.
- R8: When `cnt_load` is high, `cnt_q` takes `cnt_load_val` at the next edge and overrides any loop decrement. The position still follows the step in that cycle, and a loop step decides taken or not taken from the count held before the preset.
- R9: When `step_valid` is low, `ip_q` holds whatever values `step_kind`, `step_len` and `step_ofs` carry. `cnt_q` also holds unless a preset is applied.
- R10: Kind 2'b11 is reserved. It behaves exactly like a sequential step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | An instruction retires this cycle |
| step_kind | input | 2 | 00 sequential, 01 jump, 10 loop, 11 reserved (sequential) |
| step_len | input | LEN_W (4) | Length in bytes of the retiring instruction |
| step_ofs | input | OFS_W (8) | Signed displacement from the end of the instruction |
| cnt_load | input | 1 | Preset the counter |
| cnt_load_val | input | CNT_W (32) | Value written by the preset |
| ip_q | output | IP_W (32) | Current program position |
| cnt_q | output | CNT_W (32) | Current iteration count |

## Verification
Both results are registered. A step or preset that is driven in one cycle shows up on `ip_q` and `cnt_q` immediately after the next rising edge, and neither output has any combinational path from the inputs. The bench drives its inputs on the falling edge and advances a behavioural model at the same moment. It then compares both outputs on the following falling edge, which is exactly one edge after the stimulus. The clocked properties use a one-cycle `|=>` with `$past` of the stimulus, so they check the same single-edge latency.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [1:0] {
    K_SEQ  = 2'b00,
    K_JUMP = 2'b01,
    K_LOOP = 2'b10,
    K_RSVD = 2'b11
  } step_kind_e;

endpackage

// File: rtl/lbu_target_calc.sv
module lbu_target_calc #(
  parameter int IP_W  = 32,
  parameter int LEN_W = 4,
  parameter int OFS_W = 8
) (
  input  logic [IP_W-1:0]  ip_cur,
  input  logic [LEN_W-1:0] len,
  input  logic [OFS_W-1:0] ofs,
  output logic [IP_W-1:0]  fall_addr,
  output logic [IP_W-1:0]  tgt_addr
);

  localparam int EXT_W = IP_W - OFS_W;

  // first byte after the current instruction
  function automatic logic [IP_W-1:0] f_after(input logic [IP_W-1:0] p,
                                              input logic [LEN_W-1:0] l);
    return p + IP_W'(l);
  endfunction

  // two's complement displacement widened to the position width
  function automatic logic [IP_W-1:0] f_sext(input logic [OFS_W-1:0] d);
    return {{EXT_W{d[OFS_W-1]}}, d};
  endfunction

  always_comb begin
    fall_addr = f_after(ip_cur, len);
    tgt_addr  = fall_addr + f_sext(ofs);
  end

endmodule

// File: rtl/lbu_count_unit.sv
module lbu_count_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             dec_nz
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] c);
    return c - ONE;
  endfunction

  // the decremented count is nonzero exactly when the current count is not one
  function automatic logic f_survives(input logic [CNT_W-1:0] c);
    return c != ONE;
  endfunction

  always_comb begin
    cnt_dec = f_dec(cnt_q);
    dec_nz  = f_survives(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_en) cnt_q <= load_val;
    else if (dec_en)  cnt_q <= cnt_dec;
  end

endmodule

// File: rtl/lbu_ip_sel.sv
module lbu_ip_sel #(
  parameter int IP_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_valid,
  input  lbu_pkg::step_kind_e     kind,
  input  logic                    loop_taken,
  input  logic [IP_W-1:0]         fall_addr,
  input  logic [IP_W-1:0]         tgt_addr,
  output logic [IP_W-1:0]         ip_q
);
  import lbu_pkg::*;

  logic [IP_W-1:0] ip_nxt;

  always_comb begin
    unique case (kind)
      K_JUMP:  ip_nxt = tgt_addr;
      K_LOOP:  ip_nxt = loop_taken ? tgt_addr : fall_addr;
      default: ip_nxt = fall_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ip_q <= '0;
    else if (step_valid) ip_q <= ip_nxt;
  end

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int IP_W  = 32,
  parameter int CNT_W = 32,
  parameter int LEN_W = 4,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic [1:0]       step_kind,
  input  logic [LEN_W-1:0] step_len,
  input  logic [OFS_W-1:0] step_ofs,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  output logic [IP_W-1:0]  ip_q,
  output logic [CNT_W-1:0] cnt_q
);
  import lbu_pkg::*;

  step_kind_e      kind;
  logic            is_loop;
  logic            loop_taken;
  logic            dec_nz;
  logic [CNT_W-1:0] cnt_dec;
  logic [IP_W-1:0] fall_addr;
  logic [IP_W-1:0] tgt_addr;

  assign kind       = step_kind_e'(step_kind);
  assign is_loop    = step_valid && (kind == K_LOOP);
  assign loop_taken = is_loop && dec_nz;

  lbu_target_calc #(.IP_W(IP_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_tgt (
    .ip_cur    (ip_q),
    .len       (step_len),
    .ofs       (step_ofs),
    .fall_addr (fall_addr),
    .tgt_addr  (tgt_addr)
  );

  lbu_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_en   (is_loop),
    .load_en  (cnt_load),
    .load_val (cnt_load_val),
    .cnt_q    (cnt_q),
    .cnt_dec  (cnt_dec),
    .dec_nz   (dec_nz)
  );

  lbu_ip_sel #(.IP_W(IP_W)) u_ip (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .kind       (kind),
    .loop_taken (loop_taken),
    .fall_addr  (fall_addr),
    .tgt_addr   (tgt_addr),
    .ip_q       (ip_q)
  );

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int IP_W  = 32,
  parameter int CNT_W = 32,
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_valid,
  input logic [1:0]       step_kind,
  input logic [LEN_W-1:0] step_len,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt_load_val,
  input logic             loop_taken,
  input logic [IP_W-1:0]  tgt_addr,
  input logic [IP_W-1:0]  fall_addr,
  input logic [IP_W-1:0]  ip_q,
  input logic [CNT_W-1:0] cnt_q
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ip_q == '0 && cnt_q == '0));

  // R2 / R10
  a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind[1] == step_kind[0])
      |=> ip_q == $past(ip_q) + IP_W'($past(step_len)));

  // R3
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind == 2'b01) |=> ip_q == $past(tgt_addr));

  // R4
  a_r4_loop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind == 2'b10 && !cnt_load)
      |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R4
  a_r4_taken_leaves_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_taken && !cnt_load) |=> cnt_q != '0);

  // R4
  a_r4_exit_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind == 2'b10 && !loop_taken) |=> ip_q == $past(fall_addr));

  // R8
  a_r8_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == $past(cnt_load_val));

  // R9
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_valid && !cnt_load) |=> ($stable(ip_q) && $stable(cnt_q)));

endmodule

bind loop_branch_unit lbu_checker #(.IP_W(IP_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_valid   (step_valid),
  .step_kind    (step_kind),
  .step_len     (step_len),
  .cnt_load     (cnt_load),
  .cnt_load_val (cnt_load_val),
  .loop_taken   (loop_taken),
  .tgt_addr     (tgt_addr),
  .fall_addr    (fall_addr),
  .ip_q         (ip_q),
  .cnt_q        (cnt_q)
);

// File: tb/loop_branch_unit_tb.sv
`timescale 1ns/1ps
module loop_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic [1:0]  step_kind = 2'b00;
  logic [3:0]  step_len = 4'd0;
  logic [7:0]  step_ofs = 8'd0;
  logic        cnt_load = 1'b0;
  logic [31:0] cnt_load_val = 32'd0;
  logic [31:0] ip_q;
  logic [31:0] cnt_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_ip = 32'd0;
  logic [31:0] m_cnt = 32'd0;

  always #4 clk = ~clk;

  loop_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_kind(step_kind),
    .step_len(step_len), .step_ofs(step_ofs), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .ip_q(ip_q), .cnt_q(cnt_q)
  );

  task automatic check(input string tag);
    checks++;
    if (ip_q !== m_ip) begin
      errors++;
      $display("FAIL %s ip actual %h expected %h", tag, ip_q, m_ip);
    end
    checks++;
    if (cnt_q !== m_cnt) begin
      errors++;
      $display("FAIL %s cnt actual %h expected %h", tag, cnt_q, m_cnt);
    end
  endtask

  // called at a falling edge; drives one cycle, checks one edge later
  task automatic step(input string tag, input bit v, input logic [1:0] k,
                      input logic [3:0] l, input logic [7:0] o,
                      input bit ld, input logic [31:0] lv);
    longint signed disp;
    logic [31:0] nxt_ip, nxt_cnt, after, dest;
    step_valid = v; step_kind = k; step_len = l; step_ofs = o;
    cnt_load = ld; cnt_load_val = lv;
    disp    = (o >= 8'h80) ? longint'(o) - 256 : longint'(o);
    after   = m_ip + 32'(l);
    dest    = 32'(longint'(after) + disp);
    nxt_ip  = m_ip;
    nxt_cnt = m_cnt;
    if (v) begin
      if (k == 2'b01) nxt_ip = dest;
      else if (k == 2'b10) begin
        nxt_cnt = m_cnt - 32'd1;
        nxt_ip  = (nxt_cnt != 32'd0) ? dest : after;
      end else nxt_ip = after;
    end
    if (ld) nxt_cnt = lv;
    @(posedge clk);
    m_ip = nxt_ip; m_cnt = nxt_cnt;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step("R2 seq", 1, 2'b00, 4'd3, 8'h55, 0, 0);
    step("R2 seq", 1, 2'b00, 4'd15, 8'h00, 0, 0);
    step("R3 jump fwd", 1, 2'b01, 4'd2, 8'h10, 0, 0);
    // place a loop at 0x0C: jump from current pos to exactly 0x0C
    step("R3 jump", 1, 2'b01, 4'd2, 8'(32'h0C - (m_ip + 32'd2)), 0, 0);
    step("R8 preset", 0, 2'b10, 4'd7, 8'h33, 1, 32'd3);
    step("R7 loop at 0C", 1, 2'b10, 4'd2, 8'hFC, 0, 0);
    step("R4 loop taken", 1, 2'b10, 4'd2, 8'hFC, 0, 0);
    step("R4 loop exit", 1, 2'b10, 4'd2, 8'hFC, 0, 0);
    step("R5 zero start wraps", 1, 2'b10, 4'd2, 8'hF0, 0, 0);
    step("R6 back 128", 1, 2'b01, 4'd2, 8'h80, 0, 0);
    step("R6 fwd 127", 1, 2'b01, 4'd1, 8'h7F, 0, 0);
    step("R6 wrap fwd", 1, 2'b00, 4'd15, 8'h00, 0, 0);
    step("R8 preset with loop", 1, 2'b10, 4'd2, 8'hF8, 1, 32'd1);
    step("R8 preset with loop exit", 1, 2'b10, 4'd3, 8'h08, 1, 32'h0000_0100);
    step("R8 preset with jump", 1, 2'b01, 4'd4, 8'h04, 1, 32'hDEAD_BEEF);
    step("R9 idle loop kind", 0, 2'b10, 4'd9, 8'h81, 0, 0);
    step("R9 idle jump kind", 0, 2'b01, 4'd5, 8'h7F, 0, 0);
    step("R10 reserved kind", 1, 2'b11, 4'd6, 8'h90, 0, 0);
    step("R2 zero length", 1, 2'b00, 4'd0, 8'h00, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R4 mixed", r[0] | r[1], r[3:2], r[7:4], r[15:8],
           (r[20:17] == 4'd0), {29'd0, r[23:21]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule